// File: doc/BRIEF.md
# Dual-FIFO Interprocessor Mailbox

The block passes short messages between an application processor and an I/O co-processor. Two independent queues sit behind one shared register file. One queue carries traffic only from the application side to the I/O side (A2I). The other carries traffic only in the reverse direction (I2A). A message is a 64-bit first word plus a 32-bit payload held in the low half of a second 64-bit word. Software stages the first word, and its write of the second word pushes the whole message. On the far side, a read of the second receive word pops the head entry, and a read of the first receive word only peeks at it.

Each queue has a status/control word with full, empty and overflow flags. Four interrupt sources (empty and not-empty for each queue) are sticky. A source latches whenever its condition is seen and stays set until software writes a 1 to its acknowledge bit. Each of the two interrupt outputs is the OR of its two latched sources, each masked by its own enable bit.

Top module: `mbox_top`

## Requirements
- R1: After reset both queues are empty: the control word reads 0x20000, meaning bit 17 (empty) is set and bit 16 (full) is clear. The enable register at 0x48 reads 0 and both interrupt outputs are low.
- R2: A write to the first send word (channel base + 0x10) only stages 64 bits, and the queue stays empty. A write to the second send word (base + 0x18) pushes {staged word, wdata[31:0]}. The staged word is kept for later pushes. Channel bases are 0x50 for A2I and 0x80 for I2A.
- R3: A push while the queue is full is dropped and sets overflow bit 0 of the control word (base + 0x00). The flag stays set until a control write with wdata[0]=1.
- R4: A read of base + 0x20 returns the head's 64-bit word without popping it. A read of base + 0x28 returns the head's second word and pops it. Messages leave in push order.
- R5: A receive read on an empty queue returns 0 and leaves the read pointer unchanged.
- R6: Control bit 16 is set exactly when occupancy equals DEPTH, and bit 17 is set exactly when occupancy is 0.
- R7: The pop read (base + 0x28) returns these fields, all taken before the pop: bits 31:0 payload, 39:32 zero, 43:40 write pointer, 47:44 read pointer, 51:48 free slots, 56:52 occupancy and 63:57 zero. Pointers wrap from DEPTH-1 to 0.
- R8: The sources at 0x4C are bit 0 A2I empty, bit 1 A2I not-empty, bit 2 I2A empty and bit 3 I2A not-empty. A source latches one cycle after its condition holds and stays set after the condition goes away. A read of 0x4C returns the latches.
- R9: Writing 1 to a bit of 0x4C clears that latch for one cycle. If its condition still holds, the latch is set again in the next cycle. Otherwise it stays clear.
- R10: irq_a2i_o is the OR of latches 1:0, each masked by its enable bit at 0x48. irq_i2a_o does the same for bits 3:2. The enable register can be read back.
- R11: The two queues are independent: traffic on one changes neither the other's flags nor its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid in the cycle of the read strobe |
| irq_a2i_o | output | 1 | Level interrupt from the A2I sources |
| irq_i2a_o | output | 1 | Level interrupt from the I2A sources |

## Verification
Two functions can meet in one cycle: an acknowledge that clears a latch, and the still-true condition that would set that same latch. The bench provokes this by acknowledging an empty source while its queue is still empty. It then samples the output twice: right after the acknowledge edge it expects low, and one cycle later it expects high. The same sequence is repeated against a condition that has already gone away, where the output must stay low. The queue sweeps run every fill level from 1 to DEPTH on both channels, so the pointers wrap at many offsets. The expected field values are worked out with modular arithmetic.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned PAY_W  = 32;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned N_SRC  = 4;

  localparam logic [ADDR_W-1:0] IRQ_EN_ADDR  = 8'h48;
  localparam logic [ADDR_W-1:0] IRQ_ACK_ADDR = 8'h4C;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SEND0 = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SEND1 = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RECV0 = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RECV1 = 8'h28;

  localparam int unsigned OVF_BIT   = 0;
  localparam int unsigned FULL_BIT  = 16;
  localparam int unsigned EMPTY_BIT = 17;

  typedef struct packed {
    logic [DATA_W-1:0] w0;
    logic [PAY_W-1:0]  w1;
  } msg_t;

  function automatic logic [ADDR_W-1:0] ch_base(input int unsigned ch);
    return 8'h50 + ADDR_W'(ch * 48);
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  msg_t       data_i,
  output msg_t       head_o,
  output logic       full_o,
  output logic       empty_o,
  output logic [3:0] wptr_o,
  output logic [3:0] rptr_o,
  output logic [4:0] count_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  msg_t          mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [4:0]    cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == 5'(DEPTH));
  assign empty_o = (cnt_q == 5'd0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wp_q] <= data_i;
        wp_q        <= bump(wp_q);
      end
      if (pop_ok) rp_q <= bump(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 5'd1;
        2'b01:   cnt_q <= cnt_q - 5'd1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rp_q];
  assign wptr_o  = 4'(wp_q);
  assign rptr_o  = 4'(rp_q);
  assign count_o = cnt_q;
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_OUT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] cond_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic             en_we_i,
  input  logic [N_SRC-1:0] en_d_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] lat_o,
  output logic [N_OUT-1:0] irq_o
);
  localparam int unsigned SPO = N_SRC / N_OUT;

  logic [N_SRC-1:0] en_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      lat_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_d_i;
      // ack wins this cycle; a live condition sets the latch again next cycle
      lat_q <= ~ack_i & (lat_q | cond_i);
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign irq_o[g] = |(lat_q[g*SPO +: SPO] & en_q[g*SPO +: SPO]);
  end

  assign en_o  = en_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_a2i_o,
  output logic              irq_i2a_o
);
  logic [N_CH-1:0]             push_w, pop_w, full_w, empty_w;
  logic [N_CH-1:0][4:0]        cnt_w;
  logic [N_CH-1:0][3:0]        wptr_w, rptr_w;
  logic [N_CH-1:0][DATA_W-1:0] rd_ch;
  logic [N_SRC-1:0]            cond_w, ack_w, en_w, lat_w;
  logic [1:0]                  irq_w;
  logic                        en_we;
  logic [DATA_W-1:0]           rd_irq;
  logic                        rd_en;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ch_base(ch);

    logic              hit_ctrl, hit_s0, hit_s1, hit_r0, hit_r1;
    logic [DATA_W-1:0] w0_q, rd_l;
    logic              ovf_q;
    msg_t              head, push_msg;

    assign hit_ctrl = req_i && (addr_i == BASE + OFS_CTRL);
    assign hit_s0   = req_i && (addr_i == BASE + OFS_SEND0);
    assign hit_s1   = req_i && (addr_i == BASE + OFS_SEND1);
    assign hit_r0   = req_i && (addr_i == BASE + OFS_RECV0);
    assign hit_r1   = req_i && (addr_i == BASE + OFS_RECV1);

    assign push_w[ch] = hit_s1 & we_i;
    assign pop_w[ch]  = hit_r1 & ~we_i;
    assign push_msg   = '{w0: w0_q, w1: wdata_i[PAY_W-1:0]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w0_q  <= '0;
        ovf_q <= 1'b0;
      end else begin
        if (hit_s0 && we_i) w0_q <= wdata_i;
        if (push_w[ch] && full_w[ch]) ovf_q <= 1'b1;
        else if (hit_ctrl && we_i && wdata_i[OVF_BIT]) ovf_q <= 1'b0;
      end
    end

    mbox_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_w[ch]),
      .pop_i   (pop_w[ch]),
      .data_i  (push_msg),
      .head_o  (head),
      .full_o  (full_w[ch]),
      .empty_o (empty_w[ch]),
      .wptr_o  (wptr_w[ch]),
      .rptr_o  (rptr_w[ch]),
      .count_o (cnt_w[ch])
    );

    always_comb begin
      rd_l = '0;
      if (hit_ctrl) begin
        rd_l[OVF_BIT]   = ovf_q;
        rd_l[FULL_BIT]  = full_w[ch];
        rd_l[EMPTY_BIT] = empty_w[ch];
      end else if (hit_r0 && !empty_w[ch]) begin
        rd_l = head.w0;
      end else if (hit_r1 && !empty_w[ch]) begin
        rd_l = {7'd0, cnt_w[ch], 4'(5'(DEPTH) - cnt_w[ch]),
                rptr_w[ch], wptr_w[ch], 8'd0, head.w1};
      end
    end
    assign rd_ch[ch] = rd_l;
  end

  assign cond_w = {~empty_w[1], empty_w[1], ~empty_w[0], empty_w[0]};
  assign en_we  = req_i && we_i && (addr_i == IRQ_EN_ADDR);
  assign ack_w  = (req_i && we_i && (addr_i == IRQ_ACK_ADDR)) ? wdata_i[N_SRC-1:0] : '0;

  mbox_irq #(.N_SRC(N_SRC), .N_OUT(2)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cond_i  (cond_w),
    .ack_i   (ack_w),
    .en_we_i (en_we),
    .en_d_i  (wdata_i[N_SRC-1:0]),
    .en_o    (en_w),
    .lat_o   (lat_w),
    .irq_o   (irq_w)
  );

  assign irq_a2i_o = irq_w[0];
  assign irq_i2a_o = irq_w[1];

  always_comb begin
    rd_irq = '0;
    if (addr_i == IRQ_EN_ADDR) rd_irq[N_SRC-1:0] = en_w;
    else if (addr_i == IRQ_ACK_ADDR) rd_irq[N_SRC-1:0] = lat_w;
  end

  assign rd_en   = req_i & ~we_i;
  assign rdata_o = rd_en ? (rd_ch[0] | rd_ch[1] | rd_irq) : '0;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int unsigned DEPTH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      push_i,
  input logic [1:0]      pop_i,
  input logic [1:0]      full_i,
  input logic [1:0]      empty_i,
  input logic [1:0][4:0] cnt_i,
  input logic [1:0][3:0] rptr_i,
  input logic [3:0]      ack_i,
  input logic [3:0]      en_i,
  input logic [3:0]      lat_i,
  input logic            irq_a2i_i,
  input logic            irq_i2a_i
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    assert_flags_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(full_i[c] && empty_i[c]));
    assert_drop_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i[c] && full_i[c] |=> cnt_i[c] == 5'(DEPTH));
    assert_empty_read_still_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i[c] && empty_i[c] |=> $stable(rptr_i[c]));
    assert_pop_decrements_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i[c] && !empty_i[c] |=> cnt_i[c] == $past(cnt_i[c]) - 5'd1);
    assert_idle_keeps_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !push_i[c] && !pop_i[c] |=> $stable(cnt_i[c]));
  end

  for (genvar s = 0; s < 4; s++) begin : g_s
    assert_latch_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lat_i[s] && !ack_i[s] |=> lat_i[s]);
    assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[s] |=> !lat_i[s]);
  end

  assert_a2i_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[1:0] == 2'b00 |-> !irq_a2i_i);
  assert_i2a_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[3:2] == 2'b00 |-> !irq_i2a_i);
endmodule

bind mbox_top mbox_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .push_i    (push_w),
  .pop_i     (pop_w),
  .full_i    (full_w),
  .empty_i   (empty_w),
  .cnt_i     (cnt_w),
  .rptr_i    (rptr_w),
  .ack_i     (ack_w),
  .en_i      (en_w),
  .lat_i     (lat_w),
  .irq_a2i_i (irq_a2i_o),
  .irq_i2a_i (irq_i2a_o)
);

// File: tb/mbox_top_test.sv
`timescale 1ns/1ps
module mbox_top_test;
  localparam int DEPTH = 8;
  localparam logic [63:0] CT_EMPTY = 64'h20000, CT_FULL = 64'h10000, CT_OVF = 64'h1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq_a2i, irq_i2a;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_q0 [2][DEPTH];
  logic [31:0] m_q1 [2][DEPTH];
  int m_wp [2], m_rp [2], m_occ [2];

  always #10 clk = ~clk;

  mbox_top #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_a2i_o(irq_a2i), .irq_i2a_o(irq_i2a)
  );

  function automatic logic [7:0] bch(input int ch);
    return 8'h50 + 8'(ch * 48);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [63:0] exp);
    logic [63:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic model_add(input int ch, input logic [63:0] a, input logic [31:0] b);
    if (m_occ[ch] < DEPTH) begin
      m_q0[ch][m_wp[ch]] = a;
      m_q1[ch][m_wp[ch]] = b;
      m_wp[ch] = (m_wp[ch] + 1) % DEPTH;
      m_occ[ch]++;
    end
  endtask

  task automatic push_msg(input int ch, input logic [63:0] a, input logic [31:0] b);
    bus_wr(bch(ch) + 8'h10, a);
    bus_wr(bch(ch) + 8'h18, {32'hDEAD_BEEF, b});
    model_add(ch, a, b);
  endtask

  function automatic logic [63:0] r1_exp(input int ch);
    int rp = m_rp[ch];
    return {7'd0, 5'(m_occ[ch]), 4'(DEPTH - m_occ[ch]), 4'(rp), 4'(m_wp[ch]),
            8'd0, m_q1[ch][rp]};
  endfunction

  task automatic pop_chk(input int ch, input string tag);
    if (m_occ[ch] == 0) begin
      rd_chk(tag, bch(ch) + 8'h28, 64'd0);
    end else begin
      rd_chk(tag, bch(ch) + 8'h20, m_q0[ch][m_rp[ch]]);
      rd_chk(tag, bch(ch) + 8'h28, r1_exp(ch));
      m_rp[ch] = (m_rp[ch] + 1) % DEPTH;
      m_occ[ch]--;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    for (int c = 0; c < 2; c++) begin m_wp[c] = 0; m_rp[c] = 0; m_occ[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_a2i", {63'd0, irq_a2i}, 64'd0);
    chk("R1 irq_i2a", {63'd0, irq_i2a}, 64'd0);
    rd_chk("R1 a2i ctrl", bch(0), CT_EMPTY);
    rd_chk("R1 i2a ctrl", bch(1), CT_EMPTY);
    rd_chk("R1 enable", 8'h48, 64'd0);
    rd_chk("R8 empty sources latched", 8'h4C, 64'h5);

    // R2 staging
    bus_wr(bch(0) + 8'h10, 64'h1111_2222_3333_4444);
    rd_chk("R2 stage only", bch(0), CT_EMPTY);
    push_msg(0, 64'hA5A5_0000_1234_5678, 32'h1234_5678);
    rd_chk("R6 not empty", bch(0), 64'd0);
    rd_chk("R11 other queue untouched", bch(1), CT_EMPTY);
    rd_chk("R4 peek", bch(0) + 8'h20, 64'hA5A5_0000_1234_5678);
    pop_chk(0, "R7 fields");
    rd_chk("R6 empty after pop", bch(0), CT_EMPTY);

    // R5 empty reads
    rd_chk("R5 empty peek", bch(0) + 8'h20, 64'd0);
    pop_chk(0, "R5 empty pop");
    push_msg(0, 64'h0BAD_F00D_0000_0001, 32'h0000_0077);
    bus_wr(bch(0) + 8'h18, {32'h0, 32'h55});
    model_add(0, 64'h0BAD_F00D_0000_0001, 32'h55);
    pop_chk(0, "R5 pointer kept");
    pop_chk(0, "R2 staged word reused");

    // R4/R7 sweeps over every fill level on both queues
    for (int c = 0; c < 2; c++) begin
      for (int k = 1; k <= DEPTH; k++) begin
        for (int j = 0; j < k; j++)
          push_msg(c, {8'(c), 8'(k), 16'h0, 32'(j * 7 + k)}, 32'(32'hC0DE0000 + j + 16 * k));
        rd_chk("R6 fill level", bch(c), (k == DEPTH) ? CT_FULL : 64'd0);
        rd_chk("R11 idle queue empty", bch(1 - c), CT_EMPTY);
        for (int j = 0; j < k; j++) pop_chk(c, "R4 order");
      end
    end

    // R3 overflow
    for (int c = 0; c < 2; c++) begin
      for (int j = 0; j < DEPTH; j++) push_msg(c, 64'(100 + j), 32'(200 + j));
      push_msg(c, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
      rd_chk("R3 full and overflow", bch(c), CT_FULL | CT_OVF);
      for (int j = 0; j < DEPTH; j++) pop_chk(c, "R3 extra dropped");
      pop_chk(c, "R3 nothing left");
      rd_chk("R3 flag sticky", bch(c), CT_EMPTY | CT_OVF);
      bus_wr(bch(c), 64'h1);
      rd_chk("R3 flag cleared", bch(c), CT_EMPTY);
    end

    // R8 / R9 / R10 interrupt latches
    bus_wr(8'h4C, 64'hF);
    repeat (2) @(negedge clk);
    rd_chk("R9 live conditions re-latch", 8'h4C, 64'h5);
    bus_wr(8'h48, 64'h2);
    rd_chk("R10 enable readback", 8'h48, 64'h2);
    chk("R10 masked source", {63'd0, irq_a2i}, 64'd0);
    push_msg(0, 64'h77, 32'h77);
    repeat (2) @(negedge clk);
    chk("R10 a2i not-empty irq", {63'd0, irq_a2i}, 64'd1);
    rd_chk("R8 empty latch sticky", 8'h4C, 64'h7);
    bus_wr(8'h4C, 64'h1);
    repeat (2) @(negedge clk);
    rd_chk("R9 gone condition stays clear", 8'h4C, 64'h6);
    pop_chk(0, "R4 pop for irq");
    repeat (2) @(negedge clk);
    rd_chk("R8 not-empty sticky", 8'h4C, 64'h7);
    chk("R8 irq holds", {63'd0, irq_a2i}, 64'd1);
    bus_wr(8'h4C, 64'h2);
    chk("R9 ack drops irq", {63'd0, irq_a2i}, 64'd0);
    @(negedge clk);
    chk("R9 stays low", {63'd0, irq_a2i}, 64'd0);

    bus_wr(8'h48, 64'h1);
    bus_wr(8'h4C, 64'h1);
    chk("R9 ack cycle low", {63'd0, irq_a2i}, 64'd0);
    @(negedge clk);
    chk("R9 reasserts next cycle", {63'd0, irq_a2i}, 64'd1);

    bus_wr(8'h48, 64'h8);
    chk("R10 a2i masked", {63'd0, irq_a2i}, 64'd0);
    chk("R10 i2a idle", {63'd0, irq_i2a}, 64'd0);
    push_msg(1, 64'h99, 32'h99);
    repeat (2) @(negedge clk);
    chk("R10 i2a irq", {63'd0, irq_i2a}, 64'd1);
    chk("R11 a2i irq independent", {63'd0, irq_a2i}, 64'd0);
    pop_chk(1, "R11 i2a data");

    finish_run();
  end
endmodule